// File: doc/BRIEF.md
# Run-Length Infrared Transmitter

This block drives a consumer-infrared emitter from run-length-encoded data. A host writes bytes into a 32-entry transmit queue through a byte-wide register port. Each byte says whether the line is in the mark state (carrier bursts) or the space state (silence) and for how many bit periods it stays there. The block takes bytes from the queue one at a time, holds the line state for the encoded count of bit-period ticks, and gates a programmable carrier onto the output pin during marks. The bit-period tick comes from a prescaler outside the block.

Software keeps the queue topped up. It reads the fill count, or it waits for the low-data interrupt, which it can set to fire at one of four fill levels. When the queue runs dry, the line returns to space and the block waits for the next byte. A clear control empties the queue at once and stops the byte in progress.

The register port uses a valid/ready handshake. Writes to the control and carrier registers are always ready. A data write is ready only while the queue has a free entry. A data write offered while `wr_ready` is low is not stored, and it sets a sticky error flag. Nothing else stalls the port.

Top module: `irtx_top`

## Requirements
- R1: The queue holds 32 bytes. `fifo_count` is a 6-bit fill count that changes on the clock edge that accepts a data write or removes a byte. A byte written while the block is idle is removed one cycle after it is stored, and that removal starts its transmission.
- R2: With run-length mode on, a data byte whose bit 7 is 0 is a mark and one whose bit 7 is 1 is a space. Its bits 6:0 hold N, and the byte lasts N+1 bit periods. The first period ends at the first `bit_tick` after the byte is removed, and each later `bit_tick` ends one more period. The next byte is removed on the tick that ends the last period.
- R3: With run-length mode off, every data byte lasts exactly one bit period whatever bits 6:0 hold, with bit 7 still choosing mark or space.
- R4: Register addresses are: 0 = data (push), 1 = control, 2 = carrier, 3 = ignored. Control bits are: bit 0 interrupt enable, bit 1 run-length mode, bits 3:2 threshold code, bit 4 clear (acts, is not stored). Carrier bits are: 2:0 pulse width, 7:3 slot divider. At reset the interrupt is disabled, run-length mode is on, the threshold code is 2, the pulse width is 4 and the divider is 0.
- R5: Threshold codes 0, 1, 2 and 3 select low levels of 1, 7, 17 and 25 bytes. `irq_low` is high exactly when the interrupt enable is set and `fifo_count` is at or below the selected level.
- R6: When 32 bytes are stored, `wr_ready` is low for address 0. A data write offered then is dropped, the count stays at 32, and `tx_err` goes high on the next cycle and stays high.
- R7: A control write with bit 4 set empties the queue, ends the byte in progress and clears `tx_err`. From the next cycle `fifo_count` is 0 and `ir_out` is low.
- R8: The carrier period is 8 slots of divider+1 clocks each. During a mark, `ir_out` is high in the first pulse-width slots of each period. A pulse width of 0 keeps `ir_out` low, and a space keeps it low.
- R9: When the last byte ends with the queue empty, `ir_out` stays low until a new byte is written. The new byte then starts without waiting for a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse marking the end of each bit period |
| wr_valid | input | 1 | Register write offered |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| wr_ready | output | 1 | Write can be accepted |
| fifo_count | output | 6 | Bytes held in the transmit queue |
| irq_low | output | 1 | Transmit-low-data interrupt |
| tx_err | output | 1 | Sticky flag for a dropped data write |
| ir_out | output | 1 | Modulated infrared output |

## Verification
`fifo_count`, `tx_err` and the effects of a clear appear on the clock edge that takes the write. The bench samples them at the next falling edge, and waits two cycles after the last push so the idle block has removed its first byte. `irq_low` and `wr_ready` depend on the count through logic only, so they are read in the same half-cycle as the count. Line timing is checked in windows of 32 clocks, each closed by one `bit_tick`. The line state that follows a tick edge falls into the next window. Each window is sampled at every falling edge and recorded as mark if any carrier high was seen. Carrier duty is measured by counting high samples over 32 consecutive clocks, which is a whole number of carrier periods.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_CARR = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [1:0] thr;
    logic       rle;
    logic       irq_en;
  } ctrl_t;

  function automatic int unsigned thr_level(logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 7;
      2'd2:    return 17;
      default: return 25;
    endcase
  endfunction
endpackage

// File: rtl/irtx_fifo.sv
module irtx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/irtx_sequencer.sv
module irtx_sequencer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         abort,
  input  logic         bit_tick,
  input  logic         rle_en,
  input  logic         empty,
  input  logic [W-1:0] head,
  output logic         pop,
  output logic         mark
);
  localparam int RW = W - 1;

  logic          busy;
  logic [RW-1:0] remain;
  logic          last_period;

  assign last_period = bit_tick && (remain == '0);
  assign pop = !abort && !empty && (!busy || last_period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      mark   <= 1'b0;
      remain <= '0;
    end else if (abort) begin
      busy   <= 1'b0;
      mark   <= 1'b0;
      remain <= '0;
    end else if (pop) begin
      busy   <= 1'b1;
      mark   <= !head[W-1];
      remain <= rle_en ? head[RW-1:0] : '0;
    end else if (busy && bit_tick) begin
      if (remain == '0) begin
        busy <= 1'b0;
        mark <= 1'b0;
      end else begin
        remain <= remain - RW'(1);
      end
    end
  end
endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
  parameter int DIV_W = 5,
  parameter int PW_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic [PW_W-1:0]  pw,
  output logic             carrier_on
);
  logic [DIV_W-1:0] div_cnt;
  logic [PW_W-1:0]  slot;

  assign carrier_on = (slot < pw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      slot    <= '0;
    end else if (div_cnt >= div) begin
      div_cnt <= '0;
      slot    <= slot + PW_W'(1);
    end else begin
      div_cnt <= div_cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/irtx_top.sv
module irtx_top
  import irtx_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bit_tick,
  input  logic                       wr_valid,
  input  logic [1:0]                 wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic                       wr_ready,
  output logic [$clog2(DEPTH+1)-1:0] fifo_count,
  output logic                       irq_low,
  output logic                       tx_err,
  output logic                       ir_out
);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int PW_W  = 3;
  localparam int DIV_W = DATA_W - PW_W;

  ctrl_t             ctrl;
  logic [PW_W-1:0]   cfg_pw;
  logic [DIV_W-1:0]  cfg_div;
  logic              fifo_full, fifo_empty, fifo_pop, fifo_clr, push_ok, push_drop;
  logic              ctrl_wr, carr_wr, mark, carrier_on;
  logic [DATA_W-1:0] head;
  logic              unused_bits;

  assign ctrl_wr   = wr_valid && (wr_addr == ADDR_CTRL);
  assign carr_wr   = wr_valid && (wr_addr == ADDR_CARR);
  assign push_ok   = wr_valid && (wr_addr == ADDR_DATA) && !fifo_full;
  assign push_drop = wr_valid && (wr_addr == ADDR_DATA) && fifo_full;
  assign fifo_clr  = ctrl_wr && wr_data[4];
  assign wr_ready  = (wr_addr != ADDR_DATA) || !fifo_full;
  assign unused_bits = ^wr_data[DATA_W-1:5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '{thr: 2'd2, rle: 1'b1, irq_en: 1'b0};
      cfg_pw  <= PW_W'(4);
      cfg_div <= '0;
      tx_err  <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl <= ctrl_t'(wr_data[3:0]);
      if (carr_wr) begin
        cfg_pw  <= wr_data[PW_W-1:0];
        cfg_div <= wr_data[DATA_W-1:PW_W];
      end
      if (fifo_clr)       tx_err <= 1'b0;
      else if (push_drop) tx_err <= 1'b1;
    end
  end

  irtx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(push_ok), .din(wr_data),
    .pop(fifo_pop), .head(head), .empty(fifo_empty), .full(fifo_full),
    .count(fifo_count)
  );

  irtx_sequencer #(.W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .abort(fifo_clr), .bit_tick(bit_tick),
    .rle_en(ctrl.rle), .empty(fifo_empty), .head(head), .pop(fifo_pop),
    .mark(mark)
  );

  irtx_carrier #(.DIV_W(DIV_W), .PW_W(PW_W)) u_car (
    .clk(clk), .rst_n(rst_n), .div(cfg_div), .pw(cfg_pw),
    .carrier_on(carrier_on)
  );

  assign irq_low = ctrl.irq_en && (32'(fifo_count) <= thr_level(ctrl.thr));
  assign ir_out  = mark && carrier_on;

  logic [CW-1:0] unused_cw;
  assign unused_cw = '0;
endmodule

// File: rtl/irtx_checker.sv
module irtx_checker #(
  parameter int DEPTH = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_valid,
  input logic [1:0]                 wr_addr,
  input logic [7:0]                 wr_data,
  input logic                       wr_ready,
  input logic [$clog2(DEPTH+1)-1:0] fifo_count,
  input logic                       irq_low,
  input logic                       tx_err,
  input logic                       ir_out,
  input logic [2:0]                 cfg_pw
);
  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fifo_count) <= DEPTH);

  p_irq_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_low |-> (32'(fifo_count) <= 25));

  p_drop_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == 2'd0 && !wr_ready) |=> (tx_err && 32'(fifo_count) == DEPTH));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == 2'd1 && wr_data[4]) |=> (fifo_count == '0 && !tx_err && !ir_out));

  p_pw_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pw == 3'd0) |-> !ir_out);
endmodule

bind irtx_top irtx_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_ready(wr_ready), .fifo_count(fifo_count),
  .irq_low(irq_low), .tx_err(tx_err), .ir_out(ir_out), .cfg_pw(cfg_pw)
);

// File: tb/tb_irtx_top.sv
module tb_irtx_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       wr_valid = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       wr_ready, irq_low, tx_err, ir_out;
  logic [5:0] fifo_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irtx_top dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .fifo_count(fifo_count), .irq_low(irq_low), .tx_err(tx_err), .ir_out(ir_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_addr = 2'd0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      if (ir_out) highs++;
      @(negedge clk);
    end
  endtask

  task automatic run_windows(input int n, output logic [15:0] seen);
    seen = '0;
    for (int w = 0; w < n; w++) begin
      for (int i = 0; i < 32; i++) begin
        if (ir_out) seen[w] = 1'b1;
        bit_tick = (i == 31);
        @(negedge clk);
      end
      bit_tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    check("R4 reset count", fifo_count, 0);
    check("R4 reset irq", irq_low, 0);
    check("R4 reset err", tx_err, 0);
    check("R4 reset ir_out", ir_out, 0);
    check("R4 reset ready", wr_ready, 1);
  endtask

  task automatic t_rle_seq;
    logic [15:0] s;
    wr(2'd1, 8'h1A);
    wr(2'd0, 8'h02); wr(2'd0, 8'h81); wr(2'd0, 8'h00);
    run_windows(8, s);
    check("R2 run-length window pattern", int'(s[7:0]), int'(8'b0010_0111));
  endtask

  task automatic t_raw_seq;
    logic [15:0] s;
    int h;
    wr(2'd1, 8'h18);
    wr(2'd0, 8'h05); wr(2'd0, 8'h83); wr(2'd0, 8'h7F);
    run_windows(5, s);
    check("R3 one period per byte pattern", int'(s[4:0]), int'(5'b00101));
    count_high(16, h);
    check("R9 idle line low", h, 0);
    wr(2'd0, 8'h00);
    count_high(16, h);
    check("R9 restart without tick", int'(h > 0), 1);
    wr(2'd1, 8'h1A);
  endtask

  task automatic t_carrier;
    int h;
    wr(2'd1, 8'h1A);
    wr(2'd0, 8'h7F);
    idle(8);
    count_high(32, h);
    check("R8 default pw4 div0 highs", h, 16);
    wr(2'd2, 8'h02); idle(40);
    count_high(32, h);
    check("R8 pw2 highs", h, 8);
    wr(2'd2, 8'h0C); idle(40);
    count_high(32, h);
    check("R8 pw4 div1 highs", h, 16);
    wr(2'd2, 8'h00); idle(4);
    count_high(32, h);
    check("R8 pw0 keeps line low", h, 0);
    wr(2'd2, 8'h04);
    wr(2'd1, 8'h1A);
  endtask

  task automatic t_thresh(input logic [1:0] code, input int lvl);
    wr(2'd1, {4'b0001, code, 2'b11});
    wr(2'd0, 8'h7F);
    for (int i = 0; i < lvl; i++) wr(2'd0, 8'h00);
    idle(2);
    check("R5 count at level", fifo_count, lvl);
    check("R5 irq at level", irq_low, 1);
    wr(2'd0, 8'h00);
    idle(1);
    check("R5 irq above level", irq_low, 0);
  endtask

  task automatic t_full_clear;
    int h;
    wr(2'd1, 8'h1A);
    for (int i = 0; i < 33; i++) wr(2'd0, 8'h7F);
    idle(2);
    check("R1 count full", fifo_count, 32);
    check("R6 ready low when full", wr_ready, 0);
    check("R6 no err yet", tx_err, 0);
    wr(2'd0, 8'h55);
    check("R6 dropped write err", tx_err, 1);
    check("R6 count unchanged", fifo_count, 32);
    idle(3);
    check("R6 err sticky", tx_err, 1);
    count_high(16, h);
    check("R7 mark active before clear", int'(h > 0), 1);
    wr(2'd1, 8'h1A);
    check("R7 count cleared", fifo_count, 0);
    check("R7 err cleared", tx_err, 0);
    count_high(16, h);
    check("R7 line low after clear", h, 0);
  endtask

  task automatic t_addr3;
    wr(2'd3, 8'hFF);
    idle(2);
    check("R4 addr3 no push", fifo_count, 0);
    check("R4 addr3 irq still off", irq_low, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_addr3();
    t_rle_seq();
    t_raw_seq();
    t_carrier();
    t_thresh(2'd0, 1);
    t_thresh(2'd1, 7);
    t_thresh(2'd2, 17);
    t_thresh(2'd3, 25);
    t_full_clear();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule